// File: doc/BRIEF.md
# Peripheral Soft-Reset Sequencer

This block runs the soft-reset handshake on one peripheral's 32-bit control register, in hardware and without software polling. It reaches the register through a plain single-register port. The port has a read request, a write request, a write-data bus, a read-data bus and a ready handshake. Within the register, one bit holds the peripheral in soft reset and a second bit gates the peripheral's clock. Every change the block makes is a read followed by a write that alters only one of these two bits.

A one-cycle start pulse launches the sequence, and the just-enable input selects its length. The full sequence releases reset and ungates the clock. It then puts the peripheral back into reset and waits until the peripheral gates its own clock. Last, it releases reset and ungates the clock a second time. The short sequence only releases reset and ungates the clock once. Both end with a check that the clock is running.

Every wait is a bounded polling loop. When a wait runs out, the whole sequence starts again from the first step, up to a fixed number of attempts. When the block finishes, it pulses done together with an error flag and a code that names the wait that failed.

Top module: `periph_reset_seq`

## Requirements
- R1: After reset the block is idle: busy, done and error are low, the error code is 0, and neither register request is raised.
- R2: Every write carries the value returned by the read just before it, with at most one of bit 31 (soft reset) and bit 30 (clock gate) changed, and bits 29..0 unchanged.
- R3: With just-enable low, the register field {bit31,bit30} is written in this order: 01, 00, 10, 01, 00, starting from an initial value of 11. The polls are: bit 31 reads 0 after the first write, bit 30 reads 1 after the third write, bit 31 reads 0 after the fourth write, and bit 30 reads 0 after the fifth write.
- R4: With just-enable high, only the writes 01 and 00 are made. The final poll on bit 30 follows the second write directly.
- R5: A poll issues at most POLL_MAX reads. A condition first met on read number POLL_MAX still counts as success.
- R6: The error code is 0 on success. On a timeout it names the wait that ran out: 1 for the first release of bit 31, 2 for the wait for bit 30 to become 1, 3 for the second release of bit 31, and 4 for the final bit-30 clear. The error flag is high exactly when the code is nonzero.
- R7: A timeout restarts the sequence from the first read-modify-write. There are at most TRIES attempts, and the outcome of the last attempt is reported, including success on the final attempt.
- R8: Done is high for exactly one cycle, in the cycle after busy falls. The error flag and code stay unchanged until the next accepted start.
- R9: A start pulse while busy has no effect on the register traffic or on the result.
- R10: A request stays raised until ready is sampled high. Only one transaction is open at a time, whatever the ready latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start pulse, accepted only when idle |
| justEnI | input | 1 | Selects the short sequence when high |
| busyO | output | 1 | High while a sequence runs |
| doneO | output | 1 | One-cycle completion pulse |
| errO | output | 1 | Sequence failed, valid from done until the next start |
| errCodeO | output | 3 | Which wait timed out (0 means success) |
| regRdReqO | output | 1 | Register read request |
| regWrReqO | output | 1 | Register write request |
| regWdataO | output | DATA_W | Register write data |
| regRdataI | input | DATA_W | Register read data, valid with ready |
| regReadyI | input | 1 | Completes the pending request |

## Verification
An error in the step or phase state shows at the ports within one register transaction. The wrong bit pattern appears on the next write, or the read and write counts move away from the arithmetic totals for the chosen delays. An error in the poll or attempt counter shifts the number of reads by a whole POLL_MAX window per attempt, which is visible when done arrives. A wrong timeout code is visible in the same cycle as done. The delay sweeps put a success on the last allowed read and on the last allowed attempt, so an off-by-one in either bound is caught.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ENABLE   = 3'd1,
    ERR_RESET    = 3'd2,
    ERR_REENABLE = 3'd3,
    ERR_UNGATE   = 3'd4
  } errCode_t;

  typedef enum logic [1:0] {
    OP_KEEP,
    OP_CLR_RST,
    OP_SET_RST,
    OP_CLR_GATE
  } bitOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     pollClr;
    logic     pollInc;
    logic     tryClr;
    logic     tryInc;
    logic     finish;
    logic     clearResult;
    bitOp_t   op;
    errCode_t code;
  } dpCtl_t;

endpackage

// File: rtl/prs_datapath.sv
module prs_datapath import prs_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int RST_BIT  = 31,
  parameter int GATE_BIT = 30,
  parameter int POLL_MAX = 1000000,
  parameter int TRIES    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctlI,
  input  logic [DATA_W-1:0] regRdataI,
  output logic [DATA_W-1:0] regWdataO,
  output logic              pollLastO,
  output logic              tryLastO,
  output logic              doneO,
  output logic              errO,
  output logic [2:0]        errCodeO
);

  localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int TW = (TRIES > 1) ? $clog2(TRIES) : 1;

  logic [DATA_W-1:0] shadow;
  logic [PW-1:0]     pollCnt;
  logic [TW-1:0]     tryCnt;

  always_ff @(posedge clk) begin
    if (!rstN) shadow <= '0;
    else if (ctlI.capture) shadow <= regRdataI;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctlI.pollClr) pollCnt <= '0;
    else if (ctlI.pollInc) pollCnt <= pollCnt + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctlI.tryClr) tryCnt <= '0;
    else if (ctlI.tryInc) tryCnt <= tryCnt + TW'(1);
  end

  assign pollLastO = (pollCnt == PW'(POLL_MAX - 1));
  assign tryLastO  = (tryCnt == TW'(TRIES - 1));

  always_comb begin
    regWdataO = shadow;
    unique case (ctlI.op)
      OP_CLR_RST:  regWdataO[RST_BIT]  = 1'b0;
      OP_SET_RST:  regWdataO[RST_BIT]  = 1'b1;
      OP_CLR_GATE: regWdataO[GATE_BIT] = 1'b0;
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctlI.clearResult) begin
      doneO    <= 1'b0;
      errO     <= 1'b0;
      errCodeO <= 3'd0;
    end else if (ctlI.finish) begin
      doneO    <= 1'b1;
      errO     <= (ctlI.code != ERR_NONE);
      errCodeO <= ctlI.code;
    end else begin
      doneO    <= 1'b0;
    end
  end

  AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctlI.pollInc |-> !pollLastO); // R5
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctlI.tryInc |-> !tryLastO); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO); // R8
  AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (errO == (errCodeO != 3'd0))); // R6

endmodule

// File: rtl/prs_ctrl.sv
module prs_ctrl import prs_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int RST_BIT  = 31,
  parameter int GATE_BIT = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic              justEnI,
  input  logic              regReadyI,
  input  logic [DATA_W-1:0] regRdataI,
  input  logic              pollLastI,
  input  logic              tryLastI,
  output dpCtl_t            ctlO,
  output logic              busyO,
  output logic              regRdReqO,
  output logic              regWrReqO
);

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE, PH_POLL} phase_t;
  typedef enum logic [2:0] {
    ST_REL1, ST_UNG1, ST_ASSERT, ST_REL2, ST_UNG2, ST_FINAL
  } step_t;

  phase_t   phase, phaseNext;
  step_t    step, stepNext, stepAfter;
  logic     modeJust;
  logic     pollHit, hasPoll, advance;
  bitOp_t   stepOp;
  errCode_t stepCode;

  // per-step properties
  always_comb begin
    stepOp    = OP_KEEP;
    stepCode  = ERR_NONE;
    hasPoll   = 1'b0;
    pollHit   = 1'b1;
    stepAfter = ST_FINAL;
    unique case (step)
      ST_REL1: begin
        stepOp = OP_CLR_RST; stepCode = ERR_ENABLE; hasPoll = 1'b1;
        pollHit = !regRdataI[RST_BIT]; stepAfter = ST_UNG1;
      end
      ST_UNG1: begin
        stepOp = OP_CLR_GATE; stepAfter = modeJust ? ST_FINAL : ST_ASSERT;
      end
      ST_ASSERT: begin
        stepOp = OP_SET_RST; stepCode = ERR_RESET; hasPoll = 1'b1;
        pollHit = regRdataI[GATE_BIT]; stepAfter = ST_REL2;
      end
      ST_REL2: begin
        stepOp = OP_CLR_RST; stepCode = ERR_REENABLE; hasPoll = 1'b1;
        pollHit = !regRdataI[RST_BIT]; stepAfter = ST_UNG2;
      end
      ST_UNG2: begin
        stepOp = OP_CLR_GATE; stepAfter = ST_FINAL;
      end
      default: begin
        stepCode = ERR_UNGATE; pollHit = !regRdataI[GATE_BIT];
      end
    endcase
  end

  always_comb begin
    ctlO      = '0;
    phaseNext = phase;
    stepNext  = step;
    advance   = 1'b0;
    unique case (phase)
      PH_IDLE: if (startI) begin
        ctlO.tryClr      = 1'b1;
        ctlO.clearResult = 1'b1;
        stepNext         = ST_REL1;
        phaseNext        = PH_READ;
      end
      PH_READ: if (regReadyI) begin
        ctlO.capture = 1'b1;
        phaseNext    = PH_WRITE;
      end
      PH_WRITE: begin
        ctlO.op = stepOp;
        if (regReadyI) begin
          if (hasPoll) begin
            ctlO.pollClr = 1'b1;
            phaseNext    = PH_POLL;
          end else begin
            advance = 1'b1;
          end
        end
      end
      default: if (regReadyI) begin
        if (pollHit) begin
          if (step == ST_FINAL) begin
            ctlO.finish = 1'b1;
            ctlO.code   = ERR_NONE;
            phaseNext   = PH_IDLE;
          end else begin
            advance = 1'b1;
          end
        end else if (pollLastI) begin
          if (tryLastI) begin
            ctlO.finish = 1'b1;
            ctlO.code   = stepCode;
            phaseNext   = PH_IDLE;
          end else begin
            ctlO.tryInc = 1'b1;
            stepNext    = ST_REL1;
            phaseNext   = PH_READ;
          end
        end else begin
          ctlO.pollInc = 1'b1;
        end
      end
    endcase
    if (advance) begin
      stepNext = stepAfter;
      if (stepAfter == ST_FINAL) begin
        ctlO.pollClr = 1'b1;
        phaseNext    = PH_POLL;
      end else begin
        phaseNext = PH_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      step     <= ST_REL1;
      modeJust <= 1'b0;
    end else begin
      phase <= phaseNext;
      step  <= stepNext;
      if (phase == PH_IDLE && startI) modeJust <= justEnI;
    end
  end

  assign busyO     = (phase != PH_IDLE);
  assign regRdReqO = (phase == PH_READ) || (phase == PH_POLL);
  assign regWrReqO = (phase == PH_WRITE);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regRdReqO && !regReadyI) |=> regRdReqO); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrReqO && !regReadyI) |=> (regWrReqO && $stable(ctlO.op))); // R10

endmodule

// File: rtl/periph_reset_seq.sv
module periph_reset_seq import prs_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int RST_BIT  = 31,
  parameter int GATE_BIT = 30,
  parameter int POLL_MAX = 1000000,
  parameter int TRIES    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic              justEnI,
  output logic              busyO,
  output logic              doneO,
  output logic              errO,
  output logic [2:0]        errCodeO,
  output logic              regRdReqO,
  output logic              regWrReqO,
  output logic [DATA_W-1:0] regWdataO,
  input  logic [DATA_W-1:0] regRdataI,
  input  logic              regReadyI
);

  dpCtl_t ctl;
  logic   pollLast, tryLast;

  prs_ctrl #(
    .DATA_W(DATA_W), .RST_BIT(RST_BIT), .GATE_BIT(GATE_BIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startI(startI), .justEnI(justEnI),
    .regReadyI(regReadyI), .regRdataI(regRdataI),
    .pollLastI(pollLast), .tryLastI(tryLast),
    .ctlO(ctl), .busyO(busyO), .regRdReqO(regRdReqO), .regWrReqO(regWrReqO)
  );

  prs_datapath #(
    .DATA_W(DATA_W), .RST_BIT(RST_BIT), .GATE_BIT(GATE_BIT),
    .POLL_MAX(POLL_MAX), .TRIES(TRIES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctlI(ctl), .regRdataI(regRdataI),
    .regWdataO(regWdataO), .pollLastO(pollLast), .tryLastO(tryLast),
    .doneO(doneO), .errO(errO), .errCodeO(errCodeO)
  );

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyO) |-> doneO); // R8
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && !startI) |=> $stable(errCodeO)); // R8

endmodule

// File: tb/test_periph_reset_seq.sv
module test_periph_reset_seq;

  localparam int PM = 8;
  localparam int TR = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startTb = 1'b0;
  logic        justTb = 1'b0;
  logic        busyO, doneO, errO;
  logic [2:0]  errCodeO;
  logic        rdReq, wrReq;
  logic [31:0] wData;
  logic [31:0] rDataTb = '0;
  logic        readyTb = 1'b0;

  int checks = 0;
  int errors = 0;

  periph_reset_seq #(.POLL_MAX(PM), .TRIES(TR)) i_periph_reset_seq (
    .clk(clk), .rstN(rstN), .startI(startTb), .justEnI(justTb),
    .busyO(busyO), .doneO(doneO), .errO(errO), .errCodeO(errCodeO),
    .regRdReqO(rdReq), .regWrReqO(wrReq), .regWdataO(wData),
    .regRdataI(rDataTb), .regReadyI(readyTb)
  );

  always #4 clk = ~clk;

  // behavioural peripheral register
  logic [31:0] mReg, lastRead, failMask;
  int relCnt, gateCnt, relDelay, gateDelay, relEvents, lat, waitCnt;
  int readCnt, writeCnt, rmwBad, doneCnt;
  bit gateNever, ungateStuck;
  logic [1:0] wlog [0:15];

  task automatic doRead();
    if (relCnt > 0) begin
      relCnt--;
      rDataTb = mReg | 32'h8000_0000;
    end else begin
      if (mReg[31] && !mReg[30] && !gateNever) begin
        if (gateCnt == 0) mReg[30] = 1'b1;
        else gateCnt--;
      end
      rDataTb = mReg;
    end
    lastRead = rDataTb;
    readCnt++;
  endtask

  task automatic doWrite();
    logic [31:0] diff;
    diff = wData ^ lastRead;
    if (diff[29:0] != '0 || (diff[31] && diff[30])) rmwBad++;
    if (writeCnt < 16) wlog[writeCnt] = wData[31:30];
    writeCnt++;
    if (!wData[31] && mReg[31]) begin
      if (!failMask[relEvents]) begin
        mReg[31] = 1'b0;
        relCnt = relDelay;
      end
      relEvents++;
    end else if (wData[31] && !mReg[31]) begin
      mReg[31] = 1'b1;
      gateCnt = gateDelay;
    end
    if (!(ungateStuck && !wData[30])) mReg[30] = wData[30];
    mReg[29:0] = wData[29:0];
  endtask

  always @(negedge clk) begin
    if (doneO) doneCnt++;
    if (readyTb) begin
      readyTb = 1'b0;
      waitCnt = 0;
    end else if (rdReq || wrReq) begin
      if (waitCnt < lat) waitCnt++;
      else begin
        waitCnt = 0;
        readyTb = 1'b1;
        if (rdReq) doRead();
        else doWrite();
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runCase(input string tag, input bit just, input int relD,
                         input int gateD, input bit gNever, input bit uStuck,
                         input logic [31:0] mask, input int latency,
                         input bit extraStart, input int expCode,
                         input int expWrites, input int expReads,
                         input int seqKind);
    int cyc;
    int gotCode;
    int gotErr;
    mReg = 32'hC0A5_5A3C; lastRead = mReg; failMask = mask;
    relCnt = 0; gateCnt = 0; relDelay = relD; gateDelay = gateD;
    relEvents = 0; lat = latency; waitCnt = 0;
    readCnt = 0; writeCnt = 0; rmwBad = 0; doneCnt = 0;
    gateNever = gNever; ungateStuck = uStuck;
    @(negedge clk);
    justTb = just; startTb = 1'b1;
    @(negedge clk);
    startTb = 1'b0;
    cyc = 0;
    gotCode = -1; gotErr = -1;
    while (cyc < 4000) begin
      if (extraStart && cyc == 5) begin
        justTb = ~just; startTb = 1'b1;
      end else begin
        startTb = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (doneO) begin
        gotCode = errCodeO; gotErr = errO;
        break;
      end
    end
    startTb = 1'b0;
    if (cyc >= 4000) chk({tag, " watchdog"}, 0, 1);
    chk({tag, " code"}, gotCode, expCode);
    chk("R6 err flag", gotErr, (expCode != 0) ? 1 : 0);
    chk({tag, " writes"}, writeCnt, expWrites);
    chk({tag, " reads"}, readCnt, expReads);
    chk("R2 rmw", rmwBad, 0);
    repeat (6) @(negedge clk);
    chk("R8 done pulses", doneCnt, 1);
    chk("R8 held code", errCodeO, expCode);
    chk("R9 idle after", busyO, 0);
    if (seqKind == 1) begin
      chk("R3 w0", wlog[0], 2'b01); chk("R3 w1", wlog[1], 2'b00);
      chk("R3 w2", wlog[2], 2'b10); chk("R3 w3", wlog[3], 2'b01);
      chk("R3 w4", wlog[4], 2'b00);
    end else if (seqKind == 2) begin
      chk("R4 w0", wlog[0], 2'b01); chk("R4 w1", wlog[1], 2'b00);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doneCnt = 0; lat = 0; waitCnt = 0; mReg = '0; relCnt = 0; gateCnt = 0;
    failMask = '0; relEvents = 0; readCnt = 0; writeCnt = 0; rmwBad = 0;
    gateNever = 0; ungateStuck = 0; relDelay = 0; gateDelay = 0; lastRead = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busyO, 0); chk("R1 done", doneO, 0);
    chk("R1 err", errO, 0);   chk("R1 code", errCodeO, 0);
    chk("R1 rdreq", rdReq, 0); chk("R1 wrreq", wrReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", busyO, 0);

    runCase("R3", 0, 0, 0, 0, 0, '0, 0, 0, 0, 5, 9, 1);
    for (int d = 0; d < PM; d++)
      runCase("R5 release delay", 0, d, 0, 0, 0, '0, 0, 0, 0, 5, 9 + 2 * d, 1);
    for (int g = 0; g < PM; g++)
      runCase("R5 gate delay", 0, 0, g, 0, 0, '0, 0, 0, 0, 5, 9 + g, 1);
    for (int d = 0; d < PM; d++)
      runCase("R4", 1, d, 0, 0, 0, '0, 0, 0, 0, 2, 4 + d, 2);
    for (int l = 1; l < 4; l++)
      runCase("R10", 0, 1, 1, 0, 0, '0, l, 0, 0, 5, 12, 1);
    runCase("R9", 0, 0, 0, 0, 0, '0, 0, 1, 0, 5, 9, 1);
    runCase("R6 reset wait", 0, 0, 0, 1, 0, '0, 0, 0, 2, 3 * TR, TR * (4 + PM), 0);
    runCase("R7 retry once", 0, 0, 0, 0, 0, 32'h1, 0, 0, 0, 6, 10 + PM, 0);
    runCase("R7 last attempt", 0, 0, 0, 0, 0, 32'h3, 0, 0, 0, 7, 11 + 2 * PM, 0);
    runCase("R6 enable", 0, 0, 0, 0, 0, 32'h7, 0, 0, 1, TR, TR * (1 + PM), 0);
    runCase("R6 reenable", 0, 0, 0, 0, 0, 32'h2A, 0, 0, 3, 4 * TR, TR * (6 + PM), 0);
    runCase("R6 ungate short", 1, 0, 0, 0, 1, '0, 0, 0, 4, 2 * TR, TR * (3 + PM), 0);
    runCase("R6 ungate full", 0, 0, 0, 0, 1, '0, 0, 0, 4, 5 * TR, TR * (8 + PM), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule